// File: doc/BRIEF.md
# Dual Comparator Result and Change-Interrupt Unit

This unit is the digital back end for a pair of analog comparators. Each raw comparator bit is brought into the clock domain by a two-flop synchroniser, optionally inverted, and presented to software in two places:

- a per-channel control/status register;
- a shared snapshot register, which returns both results in a single read.

A channel can also drive its result straight onto a pin. The pin path is taken from the raw, unsynchronised bit after the polarity inversion. A separate drive-enable bit keeps control over whether the pin is actually driven.

Each channel keeps a reference latch holding the result that software last saw. The latch is reloaded whenever that channel's register is read or written. A change flag is raised on the rising edge of a mismatch between the live result and the latch, not on the mismatch level. Clearing the flag is therefore enough to re-arm it. Whether a return to the previous value raises the flag depends on whether software refreshed the latch in between.

The interrupt request combines the flags through a three-level enable chain: per-channel, peripheral and global.

Top module: `cmp_out_irq`

## Requirements
- R1: After reset all four registers read 0, both channels are disabled, `irq` is 0 and both `pin_out` and `pin_oe` bits are 0.
- R2: The result of channel i appears at bit 6 of its control register (address i). It also appears at bit 6+i of the snapshot register (address 2). The value is `raw_in[i]` XOR the polarity bit (bit 4 of the control register). It becomes visible two clock edges after `raw_in` changes, and not after one.
- R3: The snapshot register at address 2 is read-only. Writes to it change nothing.
- R4: When a channel is enabled (control bit 7) and routed (control bit 2), `pin_out[i]` equals `raw_in[i]` XOR polarity, with no clock delay. Otherwise `pin_out[i]` is 0. `pin_oe[i]` always follows control bit 1.
- R5: Change flags sit at bits 1:0 of the interrupt register (address 3). They are sticky. A software write loads them, so writing 0 clears a flag and writing 1 sets it.
- R6: A flag is set on the cycle the live result first differs from the channel's reference latch. The latch loads the live result whenever the channel's control register is read or written. Without a refresh, a return to the old value sets no flag; with a refresh, it does.
- R7: `irq` is 1 only when some flag i and its enable (interrupt register bit 4+i) are both set and the peripheral enable (bit 6) and global enable (bit 7) are set. Flags are set whether or not the request is masked.
- R8: A read strobe on a channel's control register in the cycle its mismatch edge occurs suppresses that flag set.
- R9: A disabled channel reports result 0 and never sets its flag.
- R10: When a hardware flag set and a software write to the interrupt register fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raw_in | input | 2 | Raw comparator results, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0/1 channel control, 2 snapshot, 3 interrupt |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_out | output | 2 | Per-channel pin data from the output multiplexer |
| pin_oe | output | 2 | Per-channel pin drive enable |
| irq | output | 1 | Interrupt request |

## Verification
Three events can share one clock cycle: a channel's mismatch edge, a read strobe on that channel's register, and a software write to the interrupt register. The bench provokes each pairing by changing `raw_in` and then counting exactly two rising edges before raising the strobe, so the strobe covers the edge on which the flag would be set.

The result is judged by reading the interrupt register afterwards:
- a coinciding channel read must leave the flag clear;
- a coinciding clearing write must lose to the hardware set.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int CTL_ON    = 7;
  localparam int CTL_RES   = 6;
  localparam int CTL_POL   = 4;
  localparam int CTL_ROUTE = 2;
  localparam int CTL_DRV   = 1;

  localparam int IRQ_FLAG0 = 0;
  localparam int IRQ_IE0   = 4;
  localparam int IRQ_PEN   = 6;
  localparam int IRQ_GEN   = 7;

  typedef struct packed {
    logic on;
    logic pol;
    logic route;
    logic drv;
  } ctl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic          wr_ctl,
  input  logic          touch,
  input  logic          rd_hit,
  input  logic [DW-1:0] wdata,
  output ctl_t          ctl_o,
  output logic          res_o,
  output logic          ref_o,
  output logic          set_o,
  output logic          pin_o,
  output logic          oe_o
);
  ctl_t ctl_q, ctl_d;
  logic ref_q, ref_d;
  logic mm_q, mm_d;
  logic sync_res;
  logic res;
  logic mism;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (sync_res)
  );

  assign res  = ctl_q.on & (sync_res ^ ctl_q.pol);
  assign mism = res ^ ref_q;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d.on    = wdata[CTL_ON];
      ctl_d.pol   = wdata[CTL_POL];
      ctl_d.route = wdata[CTL_ROUTE];
      ctl_d.drv   = wdata[CTL_DRV];
    end
    ref_d = touch ? res : ref_q;
    mm_d  = mism;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ref_q <= 1'b0;
      mm_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      ref_q <= ref_d;
      mm_q  <= mm_d;
    end
  end

  assign set_o = ctl_q.on & mism & ~mm_q & ~rd_hit;
  assign pin_o = (ctl_q.on & ctl_q.route) ? (raw ^ ctl_q.pol) : 1'b0;
  assign oe_o  = ctl_q.drv;
  assign ctl_o = ctl_q;
  assign res_o = res;
  assign ref_o = ref_q;
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] set_evt,
  output logic [NCH-1:0] flags,
  output logic [NCH-1:0] ie,
  output logic           pen,
  output logic           gen,
  output logic           irq
);
  logic [NCH-1:0] flag_q, flag_d, ie_q, ie_d;
  logic           pen_q, pen_d, gen_q, gen_d;

  always_comb begin
    flag_d = flag_q;
    ie_d   = ie_q;
    pen_d  = pen_q;
    gen_d  = gen_q;
    if (wr) begin
      flag_d = wdata[IRQ_FLAG0 +: NCH];
      ie_d   = wdata[IRQ_IE0 +: NCH];
      pen_d  = wdata[IRQ_PEN];
      gen_d  = wdata[IRQ_GEN];
    end
    flag_d = flag_d | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ie_q   <= '0;
      pen_q  <= 1'b0;
      gen_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      pen_q  <= pen_d;
      gen_q  <= gen_d;
    end
  end

  assign flags = flag_q;
  assign ie    = ie_q;
  assign pen   = pen_q;
  assign gen   = gen_q;
  assign irq   = (|(flag_q & ie_q)) & pen_q & gen_q;
endmodule

// File: rtl/cmp_out_irq.sv
module cmp_out_irq
  import cmp_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 2,
  parameter int DW          = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw_in,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe,
  output logic           irq
);
  localparam logic [AW-1:0] SNAP_ADDR = AW'(NCH);
  localparam logic [AW-1:0] IRQ_ADDR  = AW'(NCH + 1);

  logic [1:0]           rst_pipe;
  logic                 rst_sn;
  logic [NCH-1:0]       en_w, res_w, ref_w, set_w;
  logic [NCH-1:0]       flag_w, ie_w;
  logic                 pen_w, gen_w;
  logic [NCH-1:0][DW-1:0] ctl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ctl_t ctl;
    logic sel;
    assign sel = (addr == AW'(i));

    cmp_channel #(.SYNC_STAGES(SYNC_STAGES), .DW(DW)) u_ch (
      .clk   (clk),
      .rst_n (rst_sn),
      .raw   (raw_in[i]),
      .wr_ctl(wr_en & sel),
      .touch ((wr_en | rd_en) & sel),
      .rd_hit(rd_en & sel),
      .wdata (wdata),
      .ctl_o (ctl),
      .res_o (res_w[i]),
      .ref_o (ref_w[i]),
      .set_o (set_w[i]),
      .pin_o (pin_out[i]),
      .oe_o  (pin_oe[i])
    );

    assign en_w[i] = ctl.on;

    always_comb begin
      ctl_word[i]            = '0;
      ctl_word[i][CTL_ON]    = ctl.on;
      ctl_word[i][CTL_RES]   = res_w[i];
      ctl_word[i][CTL_POL]   = ctl.pol;
      ctl_word[i][CTL_ROUTE] = ctl.route;
      ctl_word[i][CTL_DRV]   = ctl.drv;
    end
  end

  cmp_irq_ctrl #(.NCH(NCH), .DW(DW)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wr     (wr_en && (addr == IRQ_ADDR)),
    .wdata  (wdata),
    .set_evt(set_w),
    .flags  (flag_w),
    .ie     (ie_w),
    .pen    (pen_w),
    .gen    (gen_w),
    .irq    (irq)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) rdata = ctl_word[i];
    end
    if (addr == SNAP_ADDR) rdata[DW-NCH +: NCH] = res_w;
    if (addr == IRQ_ADDR) begin
      rdata[IRQ_FLAG0 +: NCH] = flag_w;
      rdata[IRQ_IE0 +: NCH]   = ie_w;
      rdata[IRQ_PEN]          = pen_w;
      rdata[IRQ_GEN]          = gen_w;
    end
  end
endmodule

// File: rtl/cmp_out_irq_chk.sv
module cmp_out_irq_chk #(
  parameter int AW = 2,
  parameter logic [AW-1:0] IRQ_ADDR = 2'd3
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic          irq,
  input logic          pen,
  input logic          gen,
  input logic [1:0]    flags,
  input logic [1:0]    en,
  input logic [1:0]    res,
  input logic [1:0]    refv
);
  logic wr_irq;
  assign wr_irq = wr_en && (addr == IRQ_ADDR);

  // R7: request only with both upper enables
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> (pen && gen));

  // R5: flags are sticky without a software write
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (flags[0] && !wr_irq) |=> flags[0]);

  // R6: a matching level never sets a flag
  p_no_level_set_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!flags[0] && !wr_irq && (res[0] == refv[0])) |=> !flags[0]);

  // R8: read strobe on the channel register blocks the set
  p_rd_suppress_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (!flags[0] && !wr_irq && rd_en && (addr == AW'(0))) |=> !flags[0]);

  // R9: a disabled channel never raises its flag
  p_dis_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (!flags[1] && !wr_irq && !en[1]) |=> !flags[1]);
endmodule

bind cmp_out_irq cmp_out_irq_chk #(.AW(AW), .IRQ_ADDR(IRQ_ADDR)) u_chk (
  .clk   (clk),
  .rst_sn(rst_sn),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .irq   (irq),
  .pen   (pen_w),
  .gen   (gen_w),
  .flags (flag_w),
  .en    (en_w),
  .res   (res_w),
  .refv  (ref_w)
);

// File: tb/cmp_out_irq_test.sv
module cmp_out_irq_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] raw_in;
  logic       wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] pin_out, pin_oe;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;

  cmp_out_irq uut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic exp_res(logic on, logic raw, logic pol);
    return on & (raw ^ pol);
  endfunction

  function automatic logic [7:0] ctl_val(logic on, logic pol, logic route, logic drv);
    return {on, 2'b00, pol, 1'b0, route, drv, 1'b0};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; raw_in = 2'b00; wr_en = 1'b0; rd_en = 1'b0;
    addr = 2'd0; wdata = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv);
      chk(rv, 8'h00, "R1 reg");
    end
    chk({4'b0, pin_out, pin_oe}, 8'h00, "R1 pins");
    chk({7'b0, irq}, 8'h00, "R1 irq");

    // R2: enable ch0, two-edge latency
    wr(2'd0, ctl_val(1, 0, 0, 0));
    raw_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(2'd2, rv);
    chk(rv, 8'h00, "R2 one edge");
    rd(2'd2, rv);
    chk(rv, 8'h40, "R2 two edges");
    cyc(1);
    rd(2'd3, rv);
    chk(rv, 8'h01, "R5 flag set on change");

    // R6: return without refresh gives no flag
    wr(2'd3, 8'h00);
    raw_in[0] = 1'b0;
    cyc(4);
    rd(2'd3, rv);
    chk(rv, 8'h00, "R6 no refresh");
    raw_in[0] = 1'b1;
    cyc(4);
    wr(2'd3, 8'h00);
    rd(2'd0, rv);
    raw_in[0] = 1'b0;
    cyc(4);
    rd(2'd3, rv);
    chk(rv, 8'h01, "R6 refreshed return");

    // R2: polarity
    wr(2'd0, ctl_val(1, 1, 0, 0));
    cyc(3);
    rd(2'd2, rv);
    chk(rv, 8'h40, "R2 polarity snapshot");
    rd(2'd0, rv);
    chk(rv, 8'hD0, "R2 polarity ctl");

    // R5 / R7: software set and enable chain
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h02);
    rd(2'd3, rv);
    chk(rv, 8'h02, "R5 software set");
    chk({7'b0, irq}, 8'h00, "R7 no enables");
    wr(2'd3, 8'h22);
    chk({7'b0, irq}, 8'h00, "R7 ie only");
    wr(2'd3, 8'h62);
    chk({7'b0, irq}, 8'h00, "R7 no global");
    wr(2'd3, 8'hE2);
    chk({7'b0, irq}, 8'h01, "R7 all enables");
    wr(2'd3, 8'hC2);
    chk({7'b0, irq}, 8'h00, "R7 channel masked");

    // R3: snapshot is read-only
    wr(2'd2, 8'hFF);
    rd(2'd2, rv);
    chk(rv, 8'h40, "R3 snapshot write ignored");

    // R4: pin multiplexer
    wr(2'd1, ctl_val(1, 0, 1, 1));
    raw_in[1] = 1'b1;
    #1 chk({6'b0, pin_out[1], pin_oe[1]}, 8'h03, "R4 routed raw");
    wr(2'd1, ctl_val(1, 1, 1, 1));
    #1 chk({6'b0, pin_out[1], pin_oe[1]}, 8'h01, "R4 routed inverted");
    wr(2'd1, ctl_val(1, 0, 0, 1));
    #1 chk({6'b0, pin_out[1], pin_oe[1]}, 8'h01, "R4 not routed");

    // R9: disabled channel quiet
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h00);
    for (int k = 0; k < 4; k++) begin
      raw_in[1] = ~raw_in[1];
      cyc(4);
    end
    rd(2'd3, rv);
    chk(rv, 8'h00, "R9 no flag while off");
    rd(2'd2, rv);
    chk(rv & 8'h80, 8'h00, "R9 result zero while off");

    // R8: read strobe on the edge cycle
    wr(2'd0, ctl_val(1, 0, 0, 0));
    cyc(2);
    wr(2'd3, 8'h00);
    rd(2'd0, rv);
    cyc(2);
    rd(2'd3, rv);
    chk(rv, 8'h00, "R8 preamble clear");
    raw_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2'd0, rv);
    chk(rv & 8'h40, 8'h40, "R8 result during read");
    cyc(3);
    rd(2'd3, rv);
    chk(rv, 8'h00, "R8 set suppressed");

    // R10: hardware set beats software clear
    raw_in[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(2'd3, 8'h00);
    rd(2'd3, rv);
    chk(rv, 8'h01, "R10 set wins");

    // Random mix: R2 and R4
    for (int it = 0; it < 120; it++) begin
      logic [1:0] r, p;
      r = 2'($urandom);
      p = 2'($urandom);
      wr(2'd0, ctl_val(1, p[0], 1, 1));
      wr(2'd1, ctl_val(1, p[1], 1, 1));
      raw_in = r;
      #1 chk({6'b0, pin_out}, {6'b0, exp_res(1, r[1], p[1]), exp_res(1, r[0], p[0])},
             "R4 random pin");
      cyc(3);
      rd(2'd2, rv);
      chk(rv, {exp_res(1, r[1], p[1]), exp_res(1, r[0], p[0]), 6'b0}, "R2 random snapshot");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule